// File: doc/BRIEF.md
# Half-Bridge Deadtime and Enable Controller

This block drives the two gate-enable signals of one motor phase, a high-side switch and a low-side switch. It takes a high-side request that is active low and a low-side request that is active high. Both requests, and two independent enable inputs, may change at any time. They are resynchronised to the local time-base clock before use. In normal mode a decision stage makes sure that only one switch is on at a time. When one switch turns off and the other is wanted, the controller holds both off for a programmed number of clock cycles before the second switch turns on.

A configuration write port loads a deadtime value and a full-on bit. Deadtime values above 255 are limited to 255. A value of zero lets the controller go straight from one side to the other. In full-on mode the decision stage is skipped: each output follows its own request one cycle sooner than in normal mode, and both outputs may be on together. Both enables must be high for any output to be on. Three copies of the block serve a three-phase bridge. No streaming data passes through the block, so every pin is a plain level or strobe with no back-pressure.

Top module: `phase_gate_ctrl`

## Requirements
- R1: `gate_hs` is on while `hs_req_n` is 0 and `gate_ls` is on while `ls_req` is 1. In normal mode a request change that is stable before rising edge 1 shows on the output after rising edge 4 and not before.
- R2: No output is on unless `en_a` and `en_b` are both 1. Dropping either enable forces both outputs off after the third rising edge, in either mode, and restoring it allows them again with the same latency.
- R3: In normal mode, when one request is dropped and the other side is requested at the same moment, the newly requested output rises exactly DT rising edges after the old output fell, where DT is the programmed deadtime (1 to 255).
- R4: With a programmed deadtime of 0, the old output falls and the new output rises on the same rising edge.
- R5: A value written to `cfg_deadtime` that is greater than 255 acts as a deadtime of 255.
- R6: If the request for the new side is withdrawn while the deadtime is still counting, that side never turns on and both outputs stay off.
- R7: Outside full-on mode the two outputs are never on together. While both sides are requested, both outputs are off.
- R8: With full-on set (`cfg_fullon` = 1 at a write), each output follows its own request, gated by the enables, after the third rising edge. Both outputs may be on at once.
- R9: After a write that clears full-on, both outputs are off from the next rising edge. A request that is held steady turns its output on DT+1 rising edges after the write edge.
- R10: Synchronous reset (`srst` = 1 at a rising edge) turns both outputs off, clears full-on and loads a deadtime of 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| srst | input | 1 | Synchronous reset, active high |
| hs_req_n | input | 1 | High-side request, active low, asynchronous |
| ls_req | input | 1 | Low-side request, active high, asynchronous |
| en_a | input | 1 | First enable, asynchronous |
| en_b | input | 1 | Second enable, asynchronous |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_deadtime | input | 10 | Deadtime in clock cycles, limited to 255 |
| cfg_fullon | input | 1 | Full-on mode bit |
| gate_hs | output | 1 | High-side gate enable |
| gate_ls | output | 1 | Low-side gate enable |

## Verification
Directed handovers are run with deadtimes of 16, 3, 0 and an over-range value. They separate an exact gap count from off-by-one gaps, the zero-gap same-edge handover, and missing saturation. Withdrawn requests, requests to both sides at once, and enable drops separate abandoned counts, conflict handling and enable gating from the normal path. Random request streams in normal mode, with random deadtimes, test the no-overlap rule and the minimum gap. Random streams in full-on mode, with the enables toggling, test that each output tracks its request three cycles late, which tells the bypass path apart from the decision path.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_HS   = 2'd1,
    ST_LS   = 2'd2,
    ST_DEAD = 2'd3
  } pgc_state_e;
endpackage

// File: rtl/pgc_sync.sv
module pgc_sync #(
  parameter int               WIDTH   = 4,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             srst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (srst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pgc_cfg.sv
module pgc_cfg #(
  parameter int DT_IN_W  = 10,
  parameter int DT_MAX   = 255,
  parameter int DT_RESET = 16,
  localparam int DT_W    = $clog2(DT_MAX + 1)
) (
  input  logic               clk,
  input  logic               srst,
  input  logic               wr,
  input  logic [DT_IN_W-1:0] dt_in,
  input  logic               fullon_in,
  output logic [DT_W-1:0]    dt_q,
  output logic               fullon_q
);
  logic [DT_W-1:0] dt_lim;

  always_comb begin
    if (dt_in > DT_IN_W'(DT_MAX)) dt_lim = DT_W'(DT_MAX);
    else                          dt_lim = dt_in[DT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      dt_q     <= DT_W'(DT_RESET);
      fullon_q <= 1'b0;
    end else if (wr) begin
      dt_q     <= dt_lim;
      fullon_q <= fullon_in;
    end
  end
endmodule

// File: rtl/pgc_dead_fsm.sv
module pgc_dead_fsm
  import pgc_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            srst,
  input  logic            hold,
  input  logic [DT_W-1:0] dt,
  input  logic            req_hs,
  input  logic            req_ls,
  output logic            dec_hs,
  output logic            dec_ls
);
  pgc_state_e      st;
  logic [DT_W-1:0] cnt;
  logic            only_hs, only_ls, dt_zero, cnt_last;

  assign only_hs  = req_hs & ~req_ls;
  assign only_ls  = req_ls & ~req_hs;
  assign dt_zero  = (dt == '0);
  assign cnt_last = (cnt == '0) || (cnt == DT_W'(1));

  always_ff @(posedge clk) begin
    if (srst) begin
      st     <= ST_OFF;
      cnt    <= '0;
      dec_hs <= 1'b0;
      dec_ls <= 1'b0;
    end else if (hold) begin
      st     <= ST_DEAD;
      cnt    <= dt_zero ? DT_W'(1) : dt;
      dec_hs <= 1'b0;
      dec_ls <= 1'b0;
    end else begin
      unique case (st)
        ST_OFF: begin
          if (only_hs) begin
            st     <= ST_HS;
            dec_hs <= 1'b1;
          end else if (only_ls) begin
            st     <= ST_LS;
            dec_ls <= 1'b1;
          end
        end
        ST_HS: begin
          if (!only_hs) begin
            dec_hs <= 1'b0;
            if (!dt_zero) begin
              st  <= ST_DEAD;
              cnt <= dt;
            end else if (only_ls) begin
              st     <= ST_LS;
              dec_ls <= 1'b1;
            end else begin
              st <= ST_OFF;
            end
          end
        end
        ST_LS: begin
          if (!only_ls) begin
            dec_ls <= 1'b0;
            if (!dt_zero) begin
              st  <= ST_DEAD;
              cnt <= dt;
            end else if (only_hs) begin
              st     <= ST_HS;
              dec_hs <= 1'b1;
            end else begin
              st <= ST_OFF;
            end
          end
        end
        ST_DEAD: begin
          if (cnt_last) begin
            cnt <= '0;
            if (only_hs) begin
              st     <= ST_HS;
              dec_hs <= 1'b1;
            end else if (only_ls) begin
              st     <= ST_LS;
              dec_ls <= 1'b1;
            end else begin
              st <= ST_OFF;
            end
          end else begin
            cnt <= cnt - DT_W'(1);
          end
        end
        default: st <= ST_OFF;
      endcase
    end
  end
endmodule

// File: rtl/phase_gate_ctrl.sv
module phase_gate_ctrl #(
  parameter int DT_IN_W     = 10,
  parameter int DT_MAX      = 255,
  parameter int DT_RESET    = 16,
  parameter int SYNC_STAGES = 2,
  localparam int DT_W       = $clog2(DT_MAX + 1)
) (
  input  logic               clk,
  input  logic               srst,
  input  logic               hs_req_n,
  input  logic               ls_req,
  input  logic               en_a,
  input  logic               en_b,
  input  logic               cfg_we,
  input  logic [DT_IN_W-1:0] cfg_deadtime,
  input  logic               cfg_fullon,
  output logic               gate_hs,
  output logic               gate_ls
);
  localparam int NSYNC = 4;

  logic [NSYNC-1:0] raw_in, syn;
  logic             hs_n_s, ls_s, en_a_s, en_b_s, en_ok;
  logic [DT_W-1:0]  dt_q;
  logic             fullon_q;
  logic             dec_hs, dec_ls;

  assign raw_in = {en_b, en_a, ls_req, hs_req_n};

  pgc_sync #(
    .WIDTH  (NSYNC),
    .STAGES (SYNC_STAGES),
    .RST_VAL(4'b0001)
  ) u_sync (
    .clk (clk),
    .srst(srst),
    .d   (raw_in),
    .q   (syn)
  );

  assign {en_b_s, en_a_s, ls_s, hs_n_s} = syn;
  assign en_ok = en_a_s & en_b_s;

  pgc_cfg #(
    .DT_IN_W (DT_IN_W),
    .DT_MAX  (DT_MAX),
    .DT_RESET(DT_RESET)
  ) u_cfg (
    .clk      (clk),
    .srst     (srst),
    .wr       (cfg_we),
    .dt_in    (cfg_deadtime),
    .fullon_in(cfg_fullon),
    .dt_q     (dt_q),
    .fullon_q (fullon_q)
  );

  pgc_dead_fsm #(
    .DT_W(DT_W)
  ) u_fsm (
    .clk   (clk),
    .srst  (srst),
    .hold  (fullon_q),
    .dt    (dt_q),
    .req_hs(~hs_n_s),
    .req_ls(ls_s),
    .dec_hs(dec_hs),
    .dec_ls(dec_ls)
  );

  // Output multiplexer stage: full-on takes the synchronised requests directly.
  always_ff @(posedge clk) begin
    if (srst) begin
      gate_hs <= 1'b0;
      gate_ls <= 1'b0;
    end else begin
      gate_hs <= en_ok & (fullon_q ? ~hs_n_s : dec_hs);
      gate_ls <= en_ok & (fullon_q ? ls_s    : dec_ls);
    end
  end
endmodule

// File: rtl/pgc_checks.sv
module pgc_checks #(
  parameter int DT_IN_W = 10,
  parameter int DT_W    = 8,
  parameter int DT_MAX  = 255
) (
  input logic               clk,
  input logic               srst,
  input logic               hs_req_n,
  input logic               ls_req,
  input logic               en_a,
  input logic               en_b,
  input logic               cfg_we,
  input logic [DT_IN_W-1:0] cfg_deadtime,
  input logic               gate_hs,
  input logic               gate_ls,
  input logic               fullon_q,
  input logic [DT_W-1:0]    dt_q
);
  logic [2:0] age;
  logic       warm;

  always_ff @(posedge clk) begin
    if (srst)             age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;
  end
  assign warm = (age >= 3'd4);

  // R10
  reset_off_chk: assert property (@(posedge clk)
    srst |=> (!gate_hs && !gate_ls && !fullon_q));

  // R7
  no_overlap_chk: assert property (@(posedge clk) disable iff (srst)
    (warm && !$past(fullon_q)) |-> !(gate_hs && gate_ls));

  // R2
  enable_gate_chk: assert property (@(posedge clk) disable iff (srst)
    (warm && (!$past(en_a, 3) || !$past(en_b, 3))) |-> (!gate_hs && !gate_ls));

  // R8
  fullon_hs_chk: assert property (@(posedge clk) disable iff (srst)
    (warm && $past(fullon_q)) |->
      (gate_hs == ($past(en_a, 3) && $past(en_b, 3) && !$past(hs_req_n, 3))));

  // R8
  fullon_ls_chk: assert property (@(posedge clk) disable iff (srst)
    (warm && $past(fullon_q)) |->
      (gate_ls == ($past(en_a, 3) && $past(en_b, 3) && $past(ls_req, 3))));

  // R3
  ls_gap_chk: assert property (@(posedge clk) disable iff (srst)
    (warm && $rose(gate_ls) && !$past(fullon_q) && (dt_q != '0)) |-> !$past(gate_hs));

  // R3
  hs_gap_chk: assert property (@(posedge clk) disable iff (srst)
    (warm && $rose(gate_hs) && !$past(fullon_q) && (dt_q != '0)) |-> !$past(gate_ls));

  // R5
  dt_clamp_chk: assert property (@(posedge clk) disable iff (srst)
    (cfg_we && (cfg_deadtime > DT_IN_W'(DT_MAX))) |=> (dt_q == DT_W'(DT_MAX)));
endmodule

bind phase_gate_ctrl pgc_checks #(
  .DT_IN_W(DT_IN_W),
  .DT_W   (DT_W),
  .DT_MAX (DT_MAX)
) u_chk (
  .clk         (clk),
  .srst        (srst),
  .hs_req_n    (hs_req_n),
  .ls_req      (ls_req),
  .en_a        (en_a),
  .en_b        (en_b),
  .cfg_we      (cfg_we),
  .cfg_deadtime(cfg_deadtime),
  .gate_hs     (gate_hs),
  .gate_ls     (gate_ls),
  .fullon_q    (fullon_q),
  .dt_q        (dt_q)
);

// File: tb/phase_gate_ctrl_test.sv
module phase_gate_ctrl_test;
  logic       clk = 1'b0;
  logic       srst;
  logic       hs_req_n, ls_req, en_a, en_b;
  logic       cfg_we;
  logic [9:0] cfg_deadtime;
  logic       cfg_fullon;
  logic       gate_hs, gate_ls;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  phase_gate_ctrl uut (
    .clk(clk), .srst(srst), .hs_req_n(hs_req_n), .ls_req(ls_req),
    .en_a(en_a), .en_b(en_b), .cfg_we(cfg_we), .cfg_deadtime(cfg_deadtime),
    .cfg_fullon(cfg_fullon), .gate_hs(gate_hs), .gate_ls(gate_ls)
  );

  function automatic int clamp_dt(int v);
    return (v > 255) ? 255 : v;
  endfunction

  function automatic logic [1:0] fullon_expect(logic ea, logic eb, logic hn, logic l);
    return {ea & eb & l, ea & eb & ~hn};
  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cfg(int dt, logic fo);
    cfg_we       = 1'b1;
    cfg_deadtime = 10'(dt);
    cfg_fullon   = fo;
    tick(1);
    cfg_we = 1'b0;
  endtask

  // Hand over from the active side to the other; dt is the expected gap.
  task automatic handover(string req, int dt, bit to_ls);
    hs_req_n = to_ls;
    ls_req   = to_ls;
    tick(4);
    if (dt == 0) begin
      chk(req, "old side off", to_ls ? gate_hs : gate_ls, 1'b0);
      chk(req, "new side on same edge", to_ls ? gate_ls : gate_hs, 1'b1);
    end else begin
      chk(req, "old side off", to_ls ? gate_hs : gate_ls, 1'b0);
      if (dt > 1) begin
        tick(dt - 1);
        chk(req, "new side still off one edge early", to_ls ? gate_ls : gate_hs, 1'b0);
      end
      tick(1);
      chk(req, "new side on after gap", to_ls ? gate_ls : gate_hs, 1'b1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h0000_5eed));
    srst = 1'b1; hs_req_n = 1'b1; ls_req = 1'b0; en_a = 1'b0; en_b = 1'b0;
    cfg_we = 1'b0; cfg_deadtime = '0; cfg_fullon = 1'b0;
    tick(3);
    srst = 1'b0;
    chk("R10", "hs off after reset", gate_hs, 1'b0);
    chk("R10", "ls off after reset", gate_ls, 1'b0);

    // R1 latency and polarity
    en_a = 1'b1; en_b = 1'b1; hs_req_n = 1'b0;
    tick(3);
    chk("R1", "hs not yet on after edge 3", gate_hs, 1'b0);
    tick(1);
    chk("R1", "hs on after edge 4", gate_hs, 1'b1);
    chk("R1", "ls stays off", gate_ls, 1'b0);

    // R10 default deadtime of 16, R3 gap
    handover("R10", 16, 1'b1);
    cfg(3, 1'b0);
    handover("R3", 3, 1'b0);
    cfg(0, 1'b0);
    handover("R4", 0, 1'b1);
    cfg(300, 1'b0);
    handover("R5", clamp_dt(300), 1'b0);

    // R6 withdrawal during the count
    cfg(10, 1'b0);
    hs_req_n = 1'b1; ls_req = 1'b1;
    tick(6);
    ls_req = 1'b0;
    for (int i = 0; i < 30; i++) begin
      tick(1);
      chk("R6", "ls stays off after withdrawal", gate_ls, 1'b0);
      chk("R6", "hs stays off after withdrawal", gate_hs, 1'b0);
    end

    // R7 both requested
    hs_req_n = 1'b0; ls_req = 1'b1;
    for (int i = 0; i < 20; i++) begin
      tick(1);
      chk("R7", "both requested, hs off", gate_hs, 1'b0);
      chk("R7", "both requested, ls off", gate_ls, 1'b0);
    end
    ls_req = 1'b0;
    tick(4);
    chk("R1", "hs on after conflict clears", gate_hs, 1'b1);

    // R2 enables
    en_b = 1'b0;
    tick(2);
    chk("R2", "hs on two edges after en_b drop", gate_hs, 1'b1);
    tick(1);
    chk("R2", "hs off three edges after en_b drop", gate_hs, 1'b0);
    en_b = 1'b1;
    tick(3);
    chk("R2", "hs back on after en_b", gate_hs, 1'b1);
    en_a = 1'b0;
    tick(3);
    chk("R2", "hs off after en_a drop", gate_hs, 1'b0);
    en_a = 1'b1;
    tick(3);
    chk("R2", "hs back on after en_a", gate_hs, 1'b1);

    // R8 full-on
    hs_req_n = 1'b1; ls_req = 1'b0;
    tick(14);
    cfg(5, 1'b1);
    hs_req_n = 1'b0; ls_req = 1'b1;
    tick(2);
    chk("R8", "hs not on after edge 2", gate_hs, 1'b0);
    chk("R8", "ls not on after edge 2", gate_ls, 1'b0);
    tick(1);
    chk("R8", "hs on after edge 3", gate_hs, 1'b1);
    chk("R8", "ls on together after edge 3", gate_ls, 1'b1);

    // R9 leaving full-on
    ls_req = 1'b0;
    tick(4);
    chk("R8", "hs alone in full-on", gate_hs, 1'b1);
    chk("R8", "ls follows drop in full-on", gate_ls, 1'b0);
    cfg(5, 1'b0);
    for (int i = 1; i <= 5; i++) begin
      tick(1);
      chk("R9", "hs off while exit gap runs", gate_hs, 1'b0);
    end
    tick(1);
    chk("R9", "hs on DT+1 edges after exit write", gate_hs, 1'b1);

    // Random normal-mode segments: R7 overlap, R3 gap
    for (int seg = 0; seg < 6; seg++) begin
      int dt;
      int hs_off, ls_off;
      logic prev_hs, prev_ls;
      hs_req_n = 1'b1; ls_req = 1'b0; en_a = 1'b1; en_b = 1'b1;
      tick(300);
      dt = $urandom_range(0, 12);
      cfg(dt, 1'b0);
      hs_off = 1000; ls_off = 1000;
      prev_hs = gate_hs; prev_ls = gate_ls;
      for (int c = 0; c < 400; c++) begin
        tick(1);
        hs_off = gate_hs ? 0 : hs_off + 1;
        ls_off = gate_ls ? 0 : ls_off + 1;
        chk("R7", "random: no overlap", gate_hs & gate_ls, 1'b0);
        if (gate_ls && !prev_ls) chk("R3", "random: ls gap long enough", hs_off >= dt + 1, 1'b1);
        if (gate_hs && !prev_hs) chk("R3", "random: hs gap long enough", ls_off >= dt + 1, 1'b1);
        prev_hs = gate_hs; prev_ls = gate_ls;
        if ($urandom_range(0, 5) == 0) begin
          hs_req_n = 1'($urandom_range(0, 1));
          ls_req   = 1'($urandom_range(0, 1));
        end
        if ($urandom_range(0, 40) == 0) en_b = ~en_b;
        else if (!en_b && $urandom_range(0, 3) == 0) en_b = 1'b1;
      end
    end

    // Random full-on segment: R8 tracking and R2 gating
    begin
      logic [1:0] h1, h2, h3;
      hs_req_n = 1'b1; ls_req = 1'b0; en_a = 1'b1; en_b = 1'b1;
      tick(300);
      cfg(7, 1'b1);
      tick(5);
      h1 = fullon_expect(en_a, en_b, hs_req_n, ls_req);
      h2 = h1; h3 = h1;
      for (int c = 0; c < 300; c++) begin
        chk("R8", "random full-on hs", gate_hs, h3[0]);
        chk("R8", "random full-on ls", gate_ls, h3[1]);
        hs_req_n = 1'($urandom_range(0, 1));
        ls_req   = 1'($urandom_range(0, 1));
        en_a     = ($urandom_range(0, 7) != 0);
        en_b     = ($urandom_range(0, 7) != 0);
        h3 = h2; h2 = h1;
        h1 = fullon_expect(en_a, en_b, hs_req_n, ls_req);
        tick(1);
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule